// File: doc/BRIEF.md
# Serial Flash Upper-Address-Byte Command Decoder

This block is the device-side front end of a serial flash whose array is larger than a 24-bit address can reach. It watches a mode-0 serial link (chip select low frames a command, data is taken on the rising clock edge and driven on the falling edge) and turns each frame into a decoded request for the array logic behind it. Read, program and erase requests always travel in three-byte address frames. The top byte of the 32-bit array address comes from a one-byte upper-address register held inside the block. Software loads that register with a write-enable-gated command and can read it back.

The link pins are sampled by the block's own clock through a short synchronizer, so the link clock must run several times slower than `clk`. Decoded requests come out as a one-cycle pulse carrying the kind, the erase size and the full address. Program payload bytes come out one per pulse while the frame is still running. The program request itself is committed only when chip select rises on a frame of legal length. A status byte and the upper-address register can be shifted out on the data-out pin.

Top module: `spi_xaddr_decoder`

## Requirements
- R1: After reset the upper-address register is 0x00, the write-enable latch is clear, `op_valid` and `wr_data_valid` are low and `spi_miso` is 0.
- R2: A frame of opcode 0x03 followed by three address bytes, most significant first, gives one `op_valid` pulse with `op_kind`=1 (read) and `op_erase_size`=3 once the third address byte has arrived, without waiting for chip select to rise.
- R3: With the write-enable latch set, a frame of opcode 0x20, 0x52 or 0xD8 plus three address bytes gives one pulse with `op_kind`=3 (erase) when chip select rises, and `op_erase_size` 0, 1 or 2 for 4 KB, 32 KB or 64 KB.
- R4: With the latch set, opcode 0x02 plus three address bytes is followed by payload bytes. Each of the first 256 payload bytes is presented once on `wr_data` with a `wr_data_valid` pulse. When chip select rises after 1 to 256 payload bytes, one pulse with `op_kind`=2 (program) and `op_erase_size`=3 follows. With zero or more than 256 payload bytes, no program request is made.
- R5: Opcode 0x06 sets the write-enable latch. While the latch is clear, program, erase and upper-address-write frames produce no pulse, no payload and no register change.
- R6: With the latch set, opcode 0xC5 followed by one data byte loads that byte into the upper-address register when chip select rises.
- R7: After opcode 0xC8 the device shifts the upper-address register out on `spi_miso`, most significant bit first. The first bit is driven after the falling clock edge that ends the opcode byte, and the byte repeats for as long as the frame continues.
- R8: After opcode 0x05 the device shifts out a status byte in the same way as R7. Bit 0 is the `dev_busy` input, bit 1 is the write-enable latch and bits 7:2 are 0.
- R9: A frame that ends before its required byte count produces no request and leaves the upper-address register and the latch unchanged. This covers a chip select rise in the middle of a byte, which is dropped.
- R10: The latch is cleared when chip select rises to end an accepted program, erase or upper-address write.
- R11: Every read, program and erase address has the upper-address register in bits 31:24 and the three frame address bytes in bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the link pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Link clock, idles low (mode 0) |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |
| dev_busy | input | 1 | Busy flag reported in status bit 0 |
| op_valid | output | 1 | One-cycle request pulse |
| op_kind | output | 2 | 1 read, 2 program, 3 erase |
| op_erase_size | output | 2 | 0 4 KB, 1 32 KB, 2 64 KB, 3 not an erase |
| op_addr | output | 32 | Full array address |
| wr_data_valid | output | 1 | One-cycle pulse per program payload byte |
| wr_data | output | 8 | Program payload byte |

## Verification
The frames are built in several patterns. Full-length frames of every opcode are sent with and without a preceding write enable, which separates the gating of R5 from plain decoding. Truncated frames are cut at the opcode, at the address and in the middle of a bit, which shows whether completion is judged on byte count rather than on opcode alone. Program frames with 3, 256 and 257 payload bytes, and with none, probe both edges of the length window. The upper-address register is read back after loads with distinct bit patterns, and status is read with busy at 0 and at 1, so that a swapped or stuck bit in either returned byte shows up.

// File: rtl/spi_xad_pkg.sv
package spi_xad_pkg;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_PROG  = 8'h02;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_WRXA  = 8'hC5;
   localparam logic [7:0] OPC_RDXA  = 8'hC8;
   localparam logic [7:0] OPC_ER4K  = 8'h20;
   localparam logic [7:0] OPC_ER32K = 8'h52;
   localparam logic [7:0] OPC_ER64K = 8'hD8;

   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_READ  = 2'd1,
      OPK_PROG  = 2'd2,
      OPK_ERASE = 2'd3
   } op_kind_e;

   typedef enum logic [1:0] {
      ESZ_4K  = 2'd0,
      ESZ_32K = 2'd1,
      ESZ_64K = 2'd2,
      ESZ_NA  = 2'd3
   } erase_size_e;

   function automatic erase_size_e erase_size_of(input logic [7:0] opc);
      case (opc)
         OPC_ER4K:  return ESZ_4K;
         OPC_ER32K: return ESZ_32K;
         OPC_ER64K: return ESZ_64K;
         default:   return ESZ_NA;
      endcase
   endfunction

endpackage

// File: rtl/spi_xad_frontend.sv
module spi_xad_frontend #(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   localparam int BIT_CW     = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              sclk_fall,
   output logic              frame_end,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte
);

   logic sclk_s, cs_s, mosi_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk) begin
            if (rst) begin
               sclk_s <= 1'b0;
               cs_s   <= 1'b1;
               mosi_s <= 1'b0;
            end else begin
               sclk_s <= sclk;
               cs_s   <= cs_n;
               mosi_s <= mosi;
            end
         end
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
         always_ff @(posedge clk) begin
            if (rst) begin
               sclk_sr <= '0;
               cs_sr   <= '1;
               mosi_sr <= '0;
            end else begin
               sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
               cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
               mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
            end
         end
         assign sclk_s = sclk_sr[SYNC_STAGES-1];
         assign cs_s   = cs_sr[SYNC_STAGES-1];
         assign mosi_s = mosi_sr[SYNC_STAGES-1];
      end
   endgenerate

   logic sclk_d, cs_d, sclk_rise;
   logic [BIT_CW-1:0] bit_cnt;
   logic [BYTE_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
   assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
   assign frame_end = cs_s & ~cs_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         if (cs_s) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= {shreg[BYTE_W-2:0], mosi_s};
            if (bit_cnt == BIT_CW'(BYTE_W-1)) begin
               bit_cnt   <= '0;
               byte_done <= 1'b1;
               rx_byte   <= {shreg[BYTE_W-2:0], mosi_s};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_xad_cmd.sv
module spi_xad_cmd
   import spi_xad_pkg::*;
#(
   parameter int LOW_BYTES = 3,
   parameter int MAX_PROG  = 256,
   localparam int ADDR_W   = 8 * LOW_BYTES,
   localparam int CNT_W    = $clog2(MAX_PROG + LOW_BYTES + 2) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic              frame_end,
   input  logic              busy,
   output logic              op_valid,
   output op_kind_e          op_kind,
   output erase_size_e       op_esz,
   output logic [ADDR_W+7:0] op_addr,
   output logic              wr_valid,
   output logic [7:0]        wr_data,
   output logic              tx_arm,
   output logic [7:0]        tx_byte
);

   logic [7:0]        opc, xa, xa_new;
   logic [ADDR_W-1:0] low_addr;
   logic [CNT_W-1:0]  idx, ndata;
   logic              ovf, wel;
   logic              is_erase, addr_done;

   assign is_erase  = (erase_size_of(opc) != ESZ_NA);
   assign addr_done = (idx > CNT_W'(LOW_BYTES));
   assign tx_byte   = (opc == OPC_RDXA) ? xa : {6'b0, wel, busy};

   always_ff @(posedge clk) begin
      if (rst) begin
         opc      <= '0;
         xa       <= '0;
         xa_new   <= '0;
         low_addr <= '0;
         idx      <= '0;
         ndata    <= '0;
         ovf      <= 1'b0;
         wel      <= 1'b0;
         op_valid <= 1'b0;
         op_kind  <= OPK_NONE;
         op_esz   <= ESZ_NA;
         op_addr  <= '0;
         wr_valid <= 1'b0;
         wr_data  <= '0;
         tx_arm   <= 1'b0;
      end else begin
         op_valid <= 1'b0;
         wr_valid <= 1'b0;
         tx_arm   <= 1'b0;
         if (byte_done) begin
            if (idx != '1) idx <= idx + 1'b1;
            if (idx == '0) begin
               opc   <= rx_byte;
               ndata <= '0;
               ovf   <= 1'b0;
               if (rx_byte == OPC_WREN) wel <= 1'b1;
               if (rx_byte == OPC_RDSR || rx_byte == OPC_RDXA) tx_arm <= 1'b1;
            end else if (idx <= CNT_W'(LOW_BYTES)) begin
               low_addr <= {low_addr[ADDR_W-9:0], rx_byte};
               if (idx == CNT_W'(1)) xa_new <= rx_byte;
               if (idx == CNT_W'(LOW_BYTES) && opc == OPC_READ) begin
                  op_valid <= 1'b1;
                  op_kind  <= OPK_READ;
                  op_esz   <= ESZ_NA;
                  op_addr  <= {xa, low_addr[ADDR_W-9:0], rx_byte};
               end
            end else if (opc == OPC_PROG) begin
               if (ndata == CNT_W'(MAX_PROG)) begin
                  ovf <= 1'b1;
               end else begin
                  ndata <= ndata + 1'b1;
                  if (wel) begin
                     wr_valid <= 1'b1;
                     wr_data  <= rx_byte;
                  end
               end
            end
         end
         if (frame_end) begin
            idx <= '0;
            if (wel) begin
               if (opc == OPC_PROG && addr_done && ndata != '0 && !ovf) begin
                  op_valid <= 1'b1;
                  op_kind  <= OPK_PROG;
                  op_esz   <= ESZ_NA;
                  op_addr  <= {xa, low_addr};
                  wel      <= 1'b0;
               end else if (is_erase && addr_done) begin
                  op_valid <= 1'b1;
                  op_kind  <= OPK_ERASE;
                  op_esz   <= erase_size_of(opc);
                  op_addr  <= {xa, low_addr};
                  wel      <= 1'b0;
               end else if (opc == OPC_WRXA && idx >= CNT_W'(2)) begin
                  xa  <= xa_new;
                  wel <= 1'b0;
               end
            end
         end
      end
   end

   p_kind_named_r2: assert property (@(posedge clk) disable iff (rst)
      op_valid |-> op_kind != OPK_NONE);
   p_no_spurious_op_r9: assert property (@(posedge clk) disable iff (rst)
      (!byte_done && !frame_end) |=> !op_valid);
   p_wel_drop_r10: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_kind != OPK_READ) |-> !wel);
   p_xa_at_end_r6: assert property (@(posedge clk) disable iff (rst)
      (xa != $past(xa)) |-> $past(frame_end));
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> (ndata != '0 && ndata <= CNT_W'(MAX_PROG)));
   p_gate_wel_r5: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> wel);

endmodule

// File: rtl/spi_xad_tx.sv
module spi_xad_tx #(
   parameter int BYTE_W = 8,
   localparam int BIT_CW = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_fall,
   input  logic              frame_end,
   input  logic              arm,
   input  logic [BYTE_W-1:0] load_byte,
   output logic              miso
);

   logic              pend, act;
   logic [BYTE_W-1:0] sh;
   logic [BIT_CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || frame_end) begin
         pend <= 1'b0;
         act  <= 1'b0;
         sh   <= '0;
         cnt  <= '0;
      end else begin
         if (arm) pend <= 1'b1;
         if (sclk_fall) begin
            if (pend || (act && cnt == BIT_CW'(BYTE_W-1))) begin
               sh   <= load_byte;
               cnt  <= '0;
               act  <= 1'b1;
               pend <= 1'b0;
            end else if (act) begin
               sh  <= sh << 1;
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign miso = sh[BYTE_W-1];

   p_miso_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
      !(sclk_fall || frame_end) |=> $stable(miso));

endmodule

// File: rtl/spi_xaddr_decoder.sv
module spi_xaddr_decoder
   import spi_xad_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int LOW_ADDR_BYTES = 3,
   parameter int MAX_PROG_BYTES = 256
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        spi_sclk,
   input  logic                        spi_cs_n,
   input  logic                        spi_mosi,
   output logic                        spi_miso,
   input  logic                        dev_busy,
   output logic                        op_valid,
   output logic [1:0]                  op_kind,
   output logic [1:0]                  op_erase_size,
   output logic [8*LOW_ADDR_BYTES+7:0] op_addr,
   output logic                        wr_data_valid,
   output logic [7:0]                  wr_data
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (LOW_ADDR_BYTES < 2 || LOW_ADDR_BYTES > 4) begin : g_bad_addr
         $error("LOW_ADDR_BYTES must lie in 2..4");
      end
      if (MAX_PROG_BYTES < 1) begin : g_bad_prog
         $error("MAX_PROG_BYTES must be at least 1");
      end
   endgenerate

   logic        sclk_fall, frame_end, byte_done, tx_arm;
   logic [7:0]  rx_byte, tx_byte;
   op_kind_e    kind_w;
   erase_size_e esz_w;

   spi_xad_frontend #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(8)) fe_i (
      .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .sclk_fall(sclk_fall), .frame_end(frame_end),
      .byte_done(byte_done), .rx_byte(rx_byte)
   );

   spi_xad_cmd #(.LOW_BYTES(LOW_ADDR_BYTES), .MAX_PROG(MAX_PROG_BYTES)) cmd_i (
      .clk(clk), .rst(rst), .byte_done(byte_done), .rx_byte(rx_byte),
      .frame_end(frame_end), .busy(dev_busy),
      .op_valid(op_valid), .op_kind(kind_w), .op_esz(esz_w), .op_addr(op_addr),
      .wr_valid(wr_data_valid), .wr_data(wr_data),
      .tx_arm(tx_arm), .tx_byte(tx_byte)
   );

   spi_xad_tx #(.BYTE_W(8)) tx_i (
      .clk(clk), .rst(rst), .sclk_fall(sclk_fall), .frame_end(frame_end),
      .arm(tx_arm), .load_byte(tx_byte), .miso(spi_miso)
   );

   assign op_kind       = kind_w;
   assign op_erase_size = esz_w;

endmodule

// File: tb/spi_xaddr_decoder_tb_top.sv
`timescale 1ns/1ps
module spi_xaddr_decoder_tb_top;

   localparam int HP  = 8;
   localparam int GAP = 24;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst = 1'b1;
   logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, dev_busy = 1'b0;
   logic spi_miso, op_valid, wr_data_valid;
   logic [1:0] op_kind, op_erase_size;
   logic [31:0] op_addr;
   logic [7:0] wr_data;

   spi_xaddr_decoder dut_i (
      .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .dev_busy(dev_busy),
      .op_valid(op_valid), .op_kind(op_kind), .op_erase_size(op_erase_size),
      .op_addr(op_addr), .wr_data_valid(wr_data_valid), .wr_data(wr_data)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   // reference state
   logic [7:0]  m_xa  = 8'h00;
   bit          m_wel = 0;
   logic [35:0] exp_op[$];
   logic [7:0]  exp_data[$];
   logic [7:0]  tx_q[$];
   logic [7:0]  rx_q[$];

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic string req_of(input logic [1:0] k);
      case (k)
         2'd1:    return "R2/R11 read";
         2'd2:    return "R4/R11 program";
         default: return "R3/R11 erase";
      endcase
   endfunction

   // compared on every clock
   always @(negedge clk) begin
      if (!rst && !finished) begin
         if (op_valid) begin
            if (exp_op.size() == 0) check("R9 unexpected op", {op_kind, op_erase_size, op_addr}, 36'h0);
            else begin
               logic [35:0] e;
               e = exp_op.pop_front();
               check(req_of(e[35:34]), {op_kind, op_erase_size, op_addr}, e);
            end
         end
         if (wr_data_valid) begin
            if (exp_data.size() == 0) check("R5 unexpected payload", wr_data, 8'h00);
            else check("R4 payload", wr_data, exp_data.pop_front());
         end
      end
   end

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int b = 7; b >= 0; b--) begin
         spi_mosi = tx[b];
         repeat (HP) @(negedge clk);
         rx[b] = spi_miso;
         spi_sclk = 1'b1;
         repeat (HP) @(negedge clk);
         spi_sclk = 1'b0;
      end
   endtask

   // sends tx_q as one frame, applying the behavioural model
   task automatic run_frame();
      int n;
      logic [7:0] opc, r;
      logic [7:0] status_exp, xa_before;
      bit wel_before;
      n = tx_q.size();
      opc = tx_q[0];
      wel_before = m_wel;
      xa_before  = m_xa;
      status_exp = {6'b0, 1'b0, dev_busy};
      status_exp[1] = m_wel;
      if (opc == 8'h03 && n >= 4)
         exp_op.push_back({2'd1, 2'd3, m_xa, tx_q[1], tx_q[2], tx_q[3]});
      if (opc == 8'h02 && wel_before)
         for (int i = 4; i < n && i < 260; i++) exp_data.push_back(tx_q[i]);
      if (opc == 8'h02 && wel_before && n >= 5 && n <= 260)
         exp_op.push_back({2'd2, 2'd3, m_xa, tx_q[1], tx_q[2], tx_q[3]});
      if ((opc == 8'h20 || opc == 8'h52 || opc == 8'hD8) && wel_before && n >= 4)
         exp_op.push_back({2'd3, (opc == 8'h20) ? 2'd0 : (opc == 8'h52) ? 2'd1 : 2'd2,
                           m_xa, tx_q[1], tx_q[2], tx_q[3]});
      rx_q.delete();
      spi_cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         xfer(tx_q[i], r);
         rx_q.push_back(r);
      end
      repeat (HP) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (GAP) @(negedge clk);
      // model updates at frame end
      if (opc == 8'h06) m_wel = 1;
      if (opc == 8'h02 && wel_before && n >= 5 && n <= 260) m_wel = 0;
      if ((opc == 8'h20 || opc == 8'h52 || opc == 8'hD8) && wel_before && n >= 4) m_wel = 0;
      if (opc == 8'hC5 && wel_before && n >= 2) begin m_xa = tx_q[1]; m_wel = 0; end
      for (int i = 1; i < n; i++) begin
         if (opc == 8'hC8) check("R7 upper-address readback", rx_q[i], xa_before);
         if (opc == 8'h05) check("R8 status byte", rx_q[i], status_exp);
      end
      if (exp_op.size() != 0) begin
         check("R2/R3/R4 missing op", exp_op.size(), 0);
         exp_op.delete();
      end
      if (exp_data.size() != 0) begin
         check("R4 missing payload", exp_data.size(), 0);
         exp_data.delete();
      end
      tx_q.delete();
   endtask

   task automatic f1(input logic [7:0] a);
      tx_q = {a}; run_frame();
   endtask
   task automatic f2(input logic [7:0] a, input logic [7:0] b);
      tx_q = {a, b}; run_frame();
   endtask
   task automatic f4(input logic [7:0] a, input logic [23:0] ad);
      tx_q = {a, ad[23:16], ad[15:8], ad[7:0]}; run_frame();
   endtask
   task automatic prog(input logic [23:0] ad, input int len, input logic [7:0] seed);
      tx_q = {8'h02, ad[23:16], ad[15:8], ad[7:0]};
      for (int i = 0; i < len; i++) tx_q.push_back(8'(seed + 8'(i * 7)));
      run_frame();
   endtask
   task automatic status_now(input string req);
      logic [7:0] s;
      s = {6'b0, m_wel, dev_busy};
      tx_q = {8'h05, 8'h00};
      run_frame();
      check(req, rx_q[1], s);
   endtask

   task automatic partial_bits(input logic [7:0] tx, input int nbits);
      spi_cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int b = 7; b > 7 - nbits; b--) begin
         spi_mosi = tx[b];
         repeat (HP) @(negedge clk);
         spi_sclk = 1'b1;
         repeat (HP) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (HP) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (GAP) @(negedge clk);
   endtask

   initial begin
      repeat (6) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state at the ports
      check("R1 op_valid after reset", op_valid, 1'b0);
      check("R1 wr_data_valid after reset", wr_data_valid, 1'b0);
      check("R1 miso after reset", spi_miso, 1'b0);
      f2(8'hC8, 8'h00);                     // R1: register reads 0x00
      status_now("R1 status after reset");

      // R2/R11: read with upper byte 0
      f4(8'h03, 24'h123456);
      // R5: upper write without write enable is ignored
      f2(8'hC5, 8'h5A);
      f2(8'hC8, 8'h00);
      // R5/R8: write enable shows in status, busy too
      f1(8'h06);
      status_now("R8 status with latch");
      dev_busy = 1'b1;
      status_now("R8 status with busy");
      dev_busy = 1'b0;
      // R6/R7/R10
      f2(8'hC5, 8'hA7);
      tx_q = {8'hC8, 8'h00, 8'h00}; run_frame();
      status_now("R10 latch cleared after upper write");
      // R11
      f4(8'h03, 24'hFEDCBA);
      // R5: erase without latch is ignored
      f4(8'h20, 24'h001000);
      // R3 all three sizes
      f1(8'h06); f4(8'h20, 24'h00F000);
      f1(8'h06); f4(8'h52, 24'h018000);
      f1(8'h06); f4(8'hD8, 24'hFF0000);
      status_now("R10 latch cleared after erase");
      // R4 small program, after loading another upper byte
      f1(8'h06); f2(8'hC5, 8'h3C);
      f1(8'h06); prog(24'h000102, 3, 8'h11);
      status_now("R10 latch cleared after program");
      // R5: program without latch
      prog(24'h000200, 2, 8'h40);
      // R4 boundaries
      f1(8'h06); prog(24'h00FF00, 256, 8'h01);
      f1(8'h06); prog(24'h010000, 257, 8'h80);
      status_now("R9 latch kept after overlong program");
      prog(24'h020000, 0, 8'h00);
      status_now("R9 latch kept after empty program");
      // R9 short frames
      f1(8'hC5);
      tx_q = {8'h20, 8'h12, 8'h34}; run_frame();
      tx_q = {8'h03, 8'h12, 8'h34}; run_frame();
      partial_bits(8'hC5, 4);
      status_now("R9 latch kept after short frames");
      f2(8'hC8, 8'h00);
      // R9: byte dropped mid-bit, following frame decoded normally
      f4(8'h03, 24'h0000FF);
      f4(8'hD8, 24'h777777);
      status_now("R10 latch cleared after final erase");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule